// File: doc/BRIEF.md
# Motor Fault Status Register

This block gathers five protection events of a motor driver and presents them to software through a small address/data register bus. The events are overcurrent, locked rotor, overvoltage, undervoltage and thermal shutdown. Each event input is first passed through a synchronizer. The synchronized level then updates one bit of a byte-wide status register.

Some bits are sticky. The overcurrent, overvoltage and thermal shutdown bits hold their value until software writes a zero to them. The undervoltage and locked-rotor bits follow their input every cycle and ignore writes.

A second register carries one summary fault flag. The flag is the OR of the five status bits as they currently read. A current-limiting indication is also brought into the block, but it has no path to either register. Current limiting is therefore never reported as a fault.

Top module: `motor_fault_regs`

## Requirements
- R1: The status register is read at address 0x2. Its bit layout is: overcurrent at bit 0, locked rotor at bit 1, overvoltage at bit 2, undervoltage at bit 3 and thermal shutdown at bit 4. Bits 7..5 always read 0.
- R2: The overcurrent, overvoltage and thermal shutdown bits are sticky. Each is set on the third rising clock edge after its input is seen high, and it stays set after the input returns low.
- R3: A write to address 0x2 clears each sticky bit whose write-data bit is 0. A sticky bit whose write-data bit is 1 is left unchanged.
- R4: If a sticky bit's synchronized input is high in the same cycle as a clearing write, the bit stays set, because setting takes priority over clearing.
- R5: The undervoltage and locked-rotor bits show their input level with the same three-edge latency. They do not hold their value, and writes to address 0x2 have no effect on them.
- R6: The summary register is read at address 0x0. Its bit 7 is the OR of status bits 4..0 as they currently read, and its bits 6..0 read 0. Writes to address 0x0 change nothing.
- R7: The current-limiting input never changes the status register or the summary flag.
- R8: After reset, every status bit and the summary flag read 0.
- R9: Status bit 5 reads 0 even after a write of 1 to it. Any other address reads 0, and a write to another address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (4) | Register address |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | DATA_W (8) | Write data |
| rd_data | output | DATA_W (8) | Read data of the addressed register (combinational) |
| ev_ocp | input | 1 | Overcurrent event |
| ev_lrp | input | 1 | Locked-rotor event |
| ev_ovp | input | 1 | Overvoltage event |
| ev_uvlo | input | 1 | Undervoltage event |
| ev_tsd | input | 1 | Thermal shutdown event |
| ilim_active | input | 1 | Current-limit regulation active |

## Verification
The bench builds the block with its default parameters: a 4-bit address, an 8-bit data path and a two-stage synchronizer. With five event inputs, all 32 event combinations can be swept, each followed by the hold and clear phases. With a byte-wide write path, all 256 write patterns can be applied against a register whose sticky bits are all set. The short synchronizer keeps the latency fixed at three edges, so the bench can state exactly when each bit changes. It can also hold an input high across a clearing write to show that setting wins over clearing.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  localparam int NUM_EVT  = 5;
  localparam int B_OCP    = 0;
  localparam int B_LRP    = 1;
  localparam int B_OVP    = 2;
  localparam int B_UVLO   = 3;
  localparam int B_TSD    = 4;
  localparam int B_RSV    = 5;
  localparam logic [NUM_EVT-1:0] STICKY_MASK =
    (NUM_EVT'(1) << B_OCP) | (NUM_EVT'(1) << B_OVP) | (NUM_EVT'(1) << B_TSD);
  localparam logic [NUM_EVT-1:0] LIVE_MASK = ~STICKY_MASK;

  // sticky update: a set request overrides a clear request in the same cycle
  function automatic logic next_sticky(input logic set_i, input logic cur_i, input logic clr_i);
    return set_i | (cur_i & ~clr_i);
  endfunction

  function automatic logic any_fault(input logic [NUM_EVT-1:0] st);
    return |st;
  endfunction
endpackage

// File: rtl/mfr_sync.sv
module mfr_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/mfr_status.sv
module mfr_status
  import mfr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_sync,
  input  logic [NUM_EVT-1:0] clr_mask,
  input  logic               clr_rsv,
  output logic [NUM_EVT-1:0] status_q,
  output logic               rsv_q
);
  for (genvar b = 0; b < NUM_EVT; b++) begin : g_bit
    if (STICKY_MASK[b]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) status_q[b] <= 1'b0;
        else     status_q[b] <= next_sticky(evt_sync[b], status_q[b], clr_mask[b]);
      end
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst) status_q[b] <= 1'b0;
        else     status_q[b] <= evt_sync[b];
      end
    end
  end

  // reserved clear-on-zero bit with no event source
  always_ff @(posedge clk) begin
    if (rst) rsv_q <= 1'b0;
    else     rsv_q <= next_sticky(1'b0, rsv_q, clr_rsv);
  end
endmodule

// File: rtl/mfr_readmux.sv
module mfr_readmux
  import mfr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] SUMMARY_ADDR = 'h0
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_EVT-1:0] status_q,
  input  logic               rsv_q,
  output logic               fault_flag,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int FLAG_BIT = DATA_W - 1;

  assign fault_flag = any_fault(status_q);

  always_comb begin
    rd_data = '0;
    if (addr == STATUS_ADDR) begin
      rd_data[NUM_EVT-1:0] = status_q;
      rd_data[B_RSV]       = rsv_q;
    end else if (addr == SUMMARY_ADDR) begin
      rd_data[FLAG_BIT] = fault_flag;
    end
  end
endmodule

// File: rtl/motor_fault_regs.sv
module motor_fault_regs
  import mfr_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] SUMMARY_ADDR = 'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_ocp,
  input  logic              ev_lrp,
  input  logic              ev_ovp,
  input  logic              ev_uvlo,
  input  logic              ev_tsd,
  input  logic              ilim_active
);
  logic [NUM_EVT-1:0] evt_raw;
  logic [NUM_EVT-1:0] evt_sync;
  logic [NUM_EVT-1:0] clr_mask;
  logic [NUM_EVT-1:0] status_q;
  logic               rsv_q;
  logic               clr_rsv;
  logic               status_wr;
  logic               fault_flag;

  always_comb begin
    evt_raw         = '0;
    evt_raw[B_OCP]  = ev_ocp;
    evt_raw[B_LRP]  = ev_lrp;
    evt_raw[B_OVP]  = ev_ovp;
    evt_raw[B_UVLO] = ev_uvlo;
    evt_raw[B_TSD]  = ev_tsd;
  end

  assign status_wr = wr_en && (addr == STATUS_ADDR);
  assign clr_mask  = status_wr ? (~wr_data[NUM_EVT-1:0] & STICKY_MASK) : '0;
  assign clr_rsv   = status_wr && !wr_data[B_RSV];

  mfr_sync #(.WIDTH(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(evt_raw), .d_out(evt_sync)
  );

  mfr_status u_status (
    .clk(clk), .rst(rst), .evt_sync(evt_sync), .clr_mask(clr_mask),
    .clr_rsv(clr_rsv), .status_q(status_q), .rsv_q(rsv_q)
  );

  mfr_readmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR), .SUMMARY_ADDR(SUMMARY_ADDR)
  ) u_rd (
    .addr(addr), .status_q(status_q), .rsv_q(rsv_q),
    .fault_flag(fault_flag), .rd_data(rd_data)
  );
endmodule

// File: rtl/mfr_checker.sv
module mfr_checker
  import mfr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] SUMMARY_ADDR = 'h0
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  rd_data,
  input logic               ilim_active,
  input logic [NUM_EVT-1:0] evt_sync,
  input logic [NUM_EVT-1:0] status_q
);
  logic [NUM_EVT-1:0] zero_wr;
  assign zero_wr = (wr_en && addr == STATUS_ADDR) ? ~wr_data[NUM_EVT-1:0] : '0;

  // R2: a sticky bit with no clear request keeps its value
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    ((status_q & STICKY_MASK & ~zero_wr) != 0) |=>
      ((status_q & $past(status_q & STICKY_MASK & ~zero_wr)) == $past(status_q & STICKY_MASK & ~zero_wr)));

  // R3: a clearing write with the input low empties the bit
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    ((zero_wr & STICKY_MASK & ~evt_sync) != 0) |=>
      ((status_q & $past(zero_wr & STICKY_MASK & ~evt_sync)) == 0));

  // R4: a high synchronized input always sets its sticky bit
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    ((evt_sync & STICKY_MASK) != 0) |=>
      ((status_q & $past(evt_sync & STICKY_MASK)) == $past(evt_sync & STICKY_MASK)));

  // R5: live bits follow the synchronized input one edge later
  a_r5_live: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & LIVE_MASK) == ($past(evt_sync) & LIVE_MASK)));

  // R6: summary read matches the OR of the status bits, low bits zero
  a_r6_summary: assert property (@(posedge clk) disable iff (rst)
    (addr == SUMMARY_ADDR) |-> (rd_data == {(|status_q), {(DATA_W-1){1'b0}}}));

  // R9 and R1: top status bits always read zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == STATUS_ADDR) |-> (rd_data[DATA_W-1:NUM_EVT] == '0));

  // R7: current limiting alone never raises a status bit
  a_r7_ilim: assert property (@(posedge clk) disable iff (rst)
    (ilim_active && evt_sync == 0 && status_q == 0) |=> (status_q == 0));
endmodule

bind motor_fault_regs mfr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STATUS_ADDR(STATUS_ADDR), .SUMMARY_ADDR(SUMMARY_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .ilim_active(ilim_active),
  .evt_sync(evt_sync), .status_q(status_q)
);

// File: tb/motor_fault_regs_test.sv
`timescale 1ns/1ps
module motor_fault_regs_test;
  localparam logic [3:0] A_STAT = 4'h2;
  localparam logic [3:0] A_SUM  = 4'h0;
  localparam logic [3:0] A_OTHER = 4'h5;
  localparam logic [4:0] HOLD_BITS = 5'b10101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = 4'h0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ev_ocp = 0, ev_lrp = 0, ev_ovp = 0, ev_uvlo = 0, ev_tsd = 0;
  logic       ilim_active = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  motor_fault_regs uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ev_ocp(ev_ocp), .ev_lrp(ev_lrp), .ev_ovp(ev_ovp),
    .ev_uvlo(ev_uvlo), .ev_tsd(ev_tsd), .ilim_active(ilim_active)
  );

  function automatic logic [7:0] sum_of(input logic [4:0] st);
    return (st != 5'd0) ? 8'h80 : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic read_chk(input logic [3:0] a, input string req, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic drive_evt(input logic [4:0] p);
    @(negedge clk);
    ev_ocp = p[0]; ev_lrp = p[1]; ev_ovp = p[2]; ev_uvlo = p[3]; ev_tsd = p[4];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    read_chk(A_STAT, "R8 status after reset", 8'h00);
    read_chk(A_SUM, "R8 summary after reset", 8'h00);
    read_chk(A_OTHER, "R9 unmapped read", 8'h00);

    // R1 R2 R5 R6 R3: sweep all event combinations
    for (int p = 0; p < 32; p++) begin
      drive_evt(5'(p));
      read_chk(A_STAT, "R1 status with events high", {3'b000, 5'(p)});
      read_chk(A_SUM, "R6 summary with events high", sum_of(5'(p)));
      drive_evt(5'd0);
      read_chk(A_STAT, "R2 sticky hold / R5 live drop", {3'b000, 5'(p) & HOLD_BITS});
      read_chk(A_SUM, "R6 summary after events drop", sum_of(5'(p) & HOLD_BITS));
      wr(A_STAT, 8'h00);
      read_chk(A_STAT, "R3 clear by zero write", 8'h00);
      read_chk(A_SUM, "R6 summary after clear", 8'h00);
    end

    // R3 R9: all write patterns against fully set sticky bits
    for (int w = 0; w < 256; w++) begin
      drive_evt(5'b10101);
      drive_evt(5'd0);
      wr(A_STAT, 8'(w));
      read_chk(A_STAT, "R3/R9 write pattern", {3'b000, 5'(w) & HOLD_BITS});
      wr(A_STAT, 8'h00);
    end

    // R4: set wins over clear while the inputs stay high
    drive_evt(5'b10101);
    wr(A_STAT, 8'h00);
    read_chk(A_STAT, "R4 set wins during clear", 8'h15);
    drive_evt(5'd0);
    wr(A_STAT, 8'h00);
    read_chk(A_STAT, "R4 clear once input low", 8'h00);

    // R5: live bits ignore writes
    drive_evt(5'b01010);
    wr(A_STAT, 8'h00);
    read_chk(A_STAT, "R5 live bits ignore zero write", 8'h0A);
    wr(A_STAT, 8'hFF);
    read_chk(A_STAT, "R5 live bits ignore one write", 8'h0A);
    drive_evt(5'd0);
    read_chk(A_STAT, "R5 live bits follow input low", 8'h00);

    // R7: current limiting never reported
    @(negedge clk); ilim_active = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    read_chk(A_STAT, "R7 status with current limit", 8'h00);
    read_chk(A_SUM, "R7 summary with current limit", 8'h00);
    @(negedge clk); ilim_active = 1'b0;

    // R6 R9: writes elsewhere change nothing
    drive_evt(5'b00001);
    drive_evt(5'd0);
    wr(A_SUM, 8'h00);
    read_chk(A_STAT, "R6 summary write ignored", 8'h01);
    read_chk(A_SUM, "R6 summary still set", 8'h80);
    wr(A_OTHER, 8'h00);
    read_chk(A_STAT, "R9 unmapped write ignored", 8'h01);
    read_chk(A_OTHER, "R9 unmapped read stays zero", 8'h00);
    wr(A_STAT, 8'h00);
    read_chk(A_SUM, "R6 summary drops after clear", 8'h00);

    finish_run();
  end
endmodule